// File: doc/BRIEF.md
# Bus Lock Release Controller

This block drives the bus-lock output of a bus master. A command strobe with its lock bit set raises the lock in that same clock. The lock is then released in one of two ways, chosen by a mode bit carried with the command. In clock mode, the lock stays high for a fixed number of clocks. In cycle mode, the lock stays high until a set number of bus cycles have completed, and then until the master drops its request.

A bus cycle counts as complete when the address acknowledge, the timeout or the abort input is high in a clock. Once a release is in progress, later commands cannot change it: their delay and mode are discarded. Arbitration, the address and data phases, and command decoding belong to other blocks.

The control is a four-state machine:
- `ST_IDLE` is the state with no lock.
- `ST_HOLD_CLK` counts clocks.
- `ST_COUNT_CYC` counts completed cycles.
- `ST_DRAIN` waits for the master request to fall.

The transitions are:
- IDLE→HOLD_CLK on a clock-mode lock command whose delay exceeds 1.
- IDLE→COUNT_CYC on a cycle-mode lock command.
- HOLD_CLK→IDLE when the count reaches its last clock.
- COUNT_CYC→DRAIN on the completion that uses up the count.
- DRAIN→IDLE when the request is low.

All other cases stay in the current state.

Top module: `bus_lock_release`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle with the count cleared, and `lock` reads 0 while no command is presented.
- R2: In idle, `lock` is high in the same clock in which `cmd_valid` and `cmd_lock` are both 1.
- R3: With `cmd_cycle_mode`=0 (clock mode) and delay N, `lock` is high for exactly N consecutive clocks, counting the command clock. This holds for N up to 255.
- R4: A delay of 0 is treated as 1.
- R5: With `cmd_cycle_mode`=1 (cycle mode) and delay N, completions are counted starting the clock after the command. After the N-th completion, `lock` follows `mst_req` and drops in the first clock in which `mst_req` is 0. The block then returns to idle.
- R6: A completion is any clock in which at least one of `addr_ack`, `timeout`, `abort` is 1. Several of them in one clock count as a single completion.
- R7: A lock command presented while a release is in progress is ignored. The delay and mode in force stay unchanged, and so does the count (it changes only through its own decrement).
- R8: A command with `cmd_lock`=0 never raises `lock` and does not disturb a release in progress.
- R9: The mode bit selects the release rule: 0 gives clock counting and 1 gives cycle counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_lock | input | 1 | Command asks for lock |
| cmd_delay | input | 8 | Release delay, in clocks or cycles (0 treated as 1) |
| cmd_cycle_mode | input | 1 | 0 = clock mode, 1 = cycle mode |
| mst_req | input | 1 | Master request |
| addr_ack | input | 1 | Address acknowledge (completion event) |
| timeout | input | 1 | Timeout (completion event) |
| abort | input | 1 | Master abort (completion event) |
| lock | output | 1 | Bus lock |

## Verification
Two pairs of functions can meet in one clock.

The first pair is a new command and a running release. The bench issues a second lock command, with a different delay and mode, one clock after the first. It also issues a lock-clear command in the middle of a countdown. In both cases the release must end exactly where the first command placed it.

The second pair is completion counting and the request-fall rule. The bench raises two completion events in the same clock and lowers `mst_req` right after. A double count would show up as an early drop of `lock`.

// File: rtl/lock_rel_pkg.sv
package lock_rel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_HOLD_CLK  = 2'd1,
        ST_COUNT_CYC = 2'd2,
        ST_DRAIN     = 2'd3
    } lr_state_e;
endpackage

// File: rtl/lock_rel_counter.sv
module lock_rel_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));
endmodule

// File: rtl/lock_rel_fsm.sv
module lock_rel_fsm
    import lock_rel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      cyc_mode,
    input  logic      multi_clk,
    input  logic      event_hit,
    input  logic      mst_req,
    input  logic      cnt_last,
    output lr_state_e state,
    output logic      load,
    output logic      dec,
    output logic      lock
);
    lr_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (cyc_mode)
                        nxt = ST_COUNT_CYC;
                    else if (multi_clk)
                        nxt = ST_HOLD_CLK;
                end
            end
            ST_HOLD_CLK:  if (cnt_last) nxt = ST_IDLE;
            ST_COUNT_CYC: if (event_hit && cnt_last) nxt = ST_DRAIN;
            ST_DRAIN:     if (!mst_req) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        load = 1'b0;
        dec  = 1'b0;
        lock = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load = start;
                lock = start;
            end
            ST_HOLD_CLK: begin
                dec  = 1'b1;
                lock = 1'b1;
            end
            ST_COUNT_CYC: begin
                dec  = event_hit;
                lock = 1'b1;
            end
            ST_DRAIN: lock = mst_req;
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_lock_release.sv
module bus_lock_release
    import lock_rel_pkg::*;
#(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic               cmd_lock,
    input  logic [DELAY_W-1:0] cmd_delay,
    input  logic               cmd_cycle_mode,
    input  logic               mst_req,
    input  logic               addr_ack,
    input  logic               timeout,
    input  logic               abort,
    output logic               lock
);
    localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

    logic [DELAY_W-1:0] delay_eff;
    logic [DELAY_W-1:0] load_val;
    logic [DELAY_W-1:0] cnt;
    logic               cnt_last;
    logic               event_hit;
    logic               start;
    logic               load;
    logic               dec;
    lr_state_e          state;

    // R4: zero delay behaves as one
    assign delay_eff = (cmd_delay == '0) ? ONE : cmd_delay;
    // R9: clock mode counts the command clock itself
    assign load_val  = cmd_cycle_mode ? delay_eff : (delay_eff - ONE);
    // R6: simultaneous completion events merge into one
    assign event_hit = addr_ack | timeout | abort;
    assign start     = cmd_valid & cmd_lock;

    lock_rel_counter #(.W(DELAY_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .dec      (dec),
        .cnt      (cnt),
        .last     (cnt_last)
    );

    lock_rel_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cyc_mode  (cmd_cycle_mode),
        .multi_clk (load_val != '0),
        .event_hit (event_hit),
        .mst_req   (mst_req),
        .cnt_last  (cnt_last),
        .state     (state),
        .load      (load),
        .dec       (dec),
        .lock      (lock)
    );

    p_hold_ends_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD_CLK && cnt_last) |=> (state == ST_IDLE && !lock || state == ST_IDLE));

    p_count_live_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT_CYC || state == ST_HOLD_CLK) |-> (cnt != '0));

    p_drain_follows_req_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |-> (lock == mst_req));

    p_no_reload_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT_CYC && !event_hit) |=> $stable(cnt));

    p_one_step_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT_CYC && !cnt_last) |=> (cnt == $past(cnt) - {{(DELAY_W-1){1'b0}}, $past(event_hit)}));
endmodule

// File: tb/tb_bus_lock_release.sv
module tb_bus_lock_release;
    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid, cmd_lock, cmd_cycle_mode;
    logic [7:0] cmd_delay;
    logic       mst_req, addr_ack, timeout, abort;
    logic       lock;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    bus_lock_release dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_lock(cmd_lock),
        .cmd_delay(cmd_delay), .cmd_cycle_mode(cmd_cycle_mode), .mst_req(mst_req),
        .addr_ack(addr_ack), .timeout(timeout), .abort(abort), .lock(lock)
    );

    typedef struct packed {
        logic       rs;
        logic       vl;
        logic       lk;
        logic       md;
        logic [7:0] dl;
        logic       rq;
        logic [2:0] ev;
        logic       ex;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t TBL [NV] = '{
        '{1,0,0,0,8'd0,0,3'b000,0}, // 0  R1
        '{0,0,0,0,8'd0,0,3'b000,0}, // 1  R1
        '{0,1,1,0,8'd3,0,3'b000,1}, // 2  R2 clock d3
        '{0,0,0,0,8'd0,0,3'b000,1}, // 3  R3
        '{0,0,0,0,8'd0,0,3'b000,1}, // 4  R3
        '{0,0,0,0,8'd0,0,3'b000,0}, // 5  R3 released
        '{0,1,0,0,8'd5,0,3'b000,0}, // 6  R8 lock clear
        '{0,0,0,0,8'd0,0,3'b000,0}, // 7  R8
        '{0,1,1,0,8'd2,0,3'b000,1}, // 8  R3 clock d2
        '{0,1,1,1,8'd9,0,3'b000,1}, // 9  R7 ignored cmd
        '{0,0,0,0,8'd0,0,3'b000,0}, // 10 R7
        '{0,1,1,0,8'd0,0,3'b000,1}, // 11 R4 zero delay
        '{0,0,0,0,8'd0,0,3'b000,0}, // 12 R4
        '{0,1,1,1,8'd2,1,3'b100,1}, // 13 R9 cycle d2, ack not counted
        '{0,0,0,0,8'd0,1,3'b000,1}, // 14 R5
        '{0,0,0,0,8'd0,1,3'b110,1}, // 15 R6 ack+timeout
        '{0,0,0,0,8'd0,0,3'b000,1}, // 16 R6 single count
        '{0,0,0,0,8'd0,1,3'b001,1}, // 17 R5 abort
        '{0,0,0,0,8'd0,1,3'b000,1}, // 18 R5 drain req high
        '{0,0,0,0,8'd0,0,3'b000,0}, // 19 R5 req low
        '{0,0,0,0,8'd0,0,3'b000,0}, // 20 R5
        '{0,1,1,1,8'd2,1,3'b000,1}, // 21 R7 cycle d2
        '{0,1,1,0,8'd1,1,3'b100,1}, // 22 R7 second cmd
        '{0,0,0,0,8'd0,1,3'b000,1}, // 23 R7
        '{0,0,0,0,8'd0,0,3'b000,1}, // 24 R5 req low while counting
        '{0,0,0,0,8'd0,1,3'b100,1}, // 25 R7
        '{0,0,0,0,8'd0,0,3'b000,0}, // 26 R5
        '{0,0,0,0,8'd0,0,3'b000,0}, // 27
        '{0,1,1,0,8'd3,0,3'b000,1}, // 28 R8 clock d3
        '{0,1,0,0,8'd1,0,3'b000,1}, // 29 R8 clear cmd
        '{0,0,0,0,8'd0,0,3'b000,1}, // 30 R8
        '{0,0,0,0,8'd0,0,3'b000,0}  // 31 R8
    };

    task automatic drive(input logic rs, input logic vl, input logic lk, input logic md,
                         input logic [7:0] dl, input logic rq, input logic [2:0] ev);
        rst = rs; cmd_valid = vl; cmd_lock = lk; cmd_cycle_mode = md;
        cmd_delay = dl; mst_req = rq; {addr_ack, timeout, abort} = ev;
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (lock !== exp) begin
            errors++;
            $display("FAIL %s: lock=%b expected=%b at %0t", req, lock, exp, $time);
        end
    endtask

    // drive after negedge, sample before next posedge
    task automatic step(input string req, input logic exp);
        @(negedge clk);
        #1;
        check(req, exp);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: lock=%b expected=done", lock);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        drive(1, 0, 0, 0, 8'd0, 0, 3'b000);
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].rs, TBL[i].vl, TBL[i].lk, TBL[i].md, TBL[i].dl, TBL[i].rq, TBL[i].ev);
            #1;
            checks++;
            if (lock !== TBL[i].ex) begin
                errors++;
                $display("FAIL vector %0d (R1..R9 table): lock=%b expected=%b", i, lock, TBL[i].ex);
            end
            @(negedge clk);
        end

        // R1: reset in the middle of a clock-mode countdown
        drive(0, 1, 1, 0, 8'd10, 0, 3'b000);
        #1; check("R1 start", 1'b1);
        @(negedge clk);
        drive(0, 0, 0, 0, 8'd0, 0, 3'b000);
        #1; check("R1 holding", 1'b1);
        @(negedge clk);
        drive(1, 0, 0, 0, 8'd0, 0, 3'b000);
        #1; check("R1 holding before reset edge", 1'b1);
        @(negedge clk);
        drive(0, 0, 0, 0, 8'd0, 0, 3'b000);
        #1; check("R1 cleared", 1'b0);

        // R3: delay 255 in clock mode gives exactly 255 high clocks
        @(negedge clk);
        drive(0, 1, 1, 0, 8'd255, 0, 3'b000);
        begin
            int high = 0;
            #1;
            if (lock) high++;
            @(negedge clk);
            drive(0, 0, 0, 0, 8'd0, 0, 3'b000);
            for (int k = 0; k < 300; k++) begin
                #1;
                if (lock) high++;
                @(negedge clk);
            end
            checks++;
            if (high != 255) begin
                errors++;
                $display("FAIL R3 delay 255: high=%0d expected=255", high);
            end
        end

        // R5: request already low when the last completion arrives
        drive(0, 1, 1, 1, 8'd1, 1, 3'b000);
        #1; check("R5 start", 1'b1);
        @(negedge clk);
        drive(0, 0, 0, 0, 8'd0, 0, 3'b010);
        #1; check("R5 counting", 1'b1);
        @(negedge clk);
        drive(0, 0, 0, 0, 8'd0, 0, 3'b000);
        #1; check("R5 drain with request low", 1'b0);
        @(negedge clk);
        #1; check("R5 idle", 1'b0);
        step("R5 stays idle", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule